// File: doc/BRIEF.md
# Byte-Mapped Timer and Interrupt Register Block

This block is a set of sixteen byte-wide registers on a simple memory-mapped port. A register is picked by a four-bit index taken from address bits [12:9]. The block holds a 16-bit down-counting timer with a reload latch, a second free-running 16-bit counter, an auxiliary control byte, and a pair of interrupt flag and enable registers that drive one interrupt line. The remaining indices are plain read/write storage bytes. They stand in for I/O port, direction, shift and peripheral-control registers that a neighbouring block interprets.

Both counters move only on cycles where `tick_i` is high, so the bus clock and the timer rate are independent. Timer 1 always counts down. When the auxiliary byte selects continuous mode, each underflow reloads the counter from the latch and raises the timer flag. Software acknowledges the flag in one of two ways: by reading either timer-1 count byte with the read strobe, or by writing a one to the flag bit.

Top module: `periph_timer_regs`

## Requirements
- R1: The register index is `addr_i[12:9]`; all other address bits are ignored. `rdata_o` shows the addressed register combinationally. Presenting an address without `rd_en_i` has no side effect.
- R2: Indices 0, 1, 2, 3, 10, 12 and 15 are plain storage bytes. The auxiliary byte at index 11 also reads back exactly what was written.
- R3: After reset, the timer-1 counter, the timer-1 latch and the timer-2 counter are 0xFFFF. Every other register is 0, and `irq_o` is low.
- R4: Index 4 reads the timer-1 count low byte and index 5 reads the high byte. A read strobe on either index clears flag bit 6, unless an underflow sets it in the same cycle.
- R5: Index 6 (low) and index 7 (high) read and write the timer-1 latch without changing the counter.
- R6: Writing index 4 replaces only the count's low byte, and writing index 5 replaces only its high byte; the other byte keeps its current value. A write cycle does not also decrement.
- R7: On each tick, timer 1 decrements. At a count of 0 it instead reloads the latch, so one period is latch+1 ticks. That underflow sets flag bit 6 only while index-11 bits [7:6] equal 01.
- R8: Indices 8 and 9 hold timer 2. It decrements per tick, wraps from 0 to 0xFFFF, uses the same byte-merge write rule as R6, and never sets a flag.
- R9: Writing index 13 clears every flag bit written as 1; zeros leave flags alone. A read of index 13 returns `irq_o` in bit 7 and the flags in bits [6:0], where bit 6 is the timer-1 flag and bits [5:0] read 0.
- R10: A write to index 14 with bit 7 set ORs bits [6:0] into the enable mask. With bit 7 clear, it clears the enable bits written as 1. A read returns the mask with bit 7 as 0.
- R11: `irq_o` is high exactly when some flag bit and its enable bit are both 1.
- R12: From reset, with continuous mode selected and the latch and counter untouched, flag bit 6 first sets on the 65536th tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter advance enable, one tick per high cycle |
| addr_i | input | 13 | Byte address; bits [12:9] select the register |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| rd_en_i | input | 1 | Read strobe; carries the read side effect of R4 |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `wr_en_i` and `rd_en_i` are never high in the same cycle. They also assume that a strobe's address and data are steady for the whole cycle. The acknowledge and clear properties exclude cycles in which an underflow occurs at the same time. The bench keeps to these assumptions: it raises `tick_i` only in cycles with no strobe, and it issues one strobe per cycle. So a flag is never set and cleared in the same cycle, and the expected values follow from the order of operations alone.

// File: rtl/periph_timer_pkg.sv
package periph_timer_pkg;
  localparam int DATA_W   = 8;
  localparam int CNT_W    = 2 * DATA_W;
  localparam int NUM_REGS = 16;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int FLAG_W   = DATA_W - 1;
  localparam int T1_FLAG  = 6;

  localparam logic [IDX_W-1:0] IX_T1_LO   = 4'd4;
  localparam logic [IDX_W-1:0] IX_T1_HI   = 4'd5;
  localparam logic [IDX_W-1:0] IX_LAT_LO  = 4'd6;
  localparam logic [IDX_W-1:0] IX_LAT_HI  = 4'd7;
  localparam logic [IDX_W-1:0] IX_T2_LO   = 4'd8;
  localparam logic [IDX_W-1:0] IX_T2_HI   = 4'd9;
  localparam logic [IDX_W-1:0] IX_AUX     = 4'd11;
  localparam logic [IDX_W-1:0] IX_FLAGS   = 4'd13;
  localparam logic [IDX_W-1:0] IX_ENABLE  = 4'd14;

  // indices kept as plain storage bytes
  localparam logic [NUM_REGS-1:0] STORE_MASK = 16'h940F;

  localparam logic [1:0] AUX_T1_CONT = 2'b01;
endpackage

// File: rtl/periph_down_counter.sv
module periph_down_counter #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  reload_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              underflow_o
);
  logic [CNT_W-1:0] cnt_q, merged;

  always_comb begin
    merged = cnt_q;
    if (wr_lo_i) merged[DATA_W-1:0]     = wdata_i;
    if (wr_hi_i) merged[CNT_W-1:DATA_W] = wdata_i[CNT_W-DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '1;
    else if (wr_lo_i | wr_hi_i) cnt_q <= merged;
    else if (tick_i)            cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
  end

  assign underflow_o = tick_i & (cnt_q == '0) & ~(wr_lo_i | wr_hi_i);
  assign count_o     = cnt_q;
endmodule

// File: rtl/periph_irq_ctrl.sv
module periph_irq_ctrl #(
  parameter int FLAG_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FLAG_W-1:0] set_i,
  input  logic [FLAG_W-1:0] clr_i,
  input  logic            en_wr_i,
  input  logic [FLAG_W:0] en_wdata_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] enables_o,
  output logic            irq_o
);
  logic [FLAG_W-1:0] flag_q, en_q;

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else if (en_wr_i) begin
      if (en_wdata_i[FLAG_W]) en_q <= en_q | en_wdata_i[FLAG_W-1:0];
      else                    en_q <= en_q & ~en_wdata_i[FLAG_W-1:0];
    end
  end

  assign flags_o   = flag_q;
  assign enables_o = en_q;
  assign irq_o     = |(flag_q & en_q);
endmodule

// File: rtl/periph_timer_regs.sv
module periph_timer_regs
  import periph_timer_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int IDX_LSB = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [IDX_W-1:0]  idx_w;
  logic [DATA_W-1:0] store_rd [NUM_REGS];
  logic [DATA_W-1:0] acr_q;
  logic [CNT_W-1:0]  t1_latch_q, t1_count, t2_count;
  logic              t1_uf, t2_uf;
  logic [FLAG_W-1:0] flag_set, flag_clr, ifr, ier;
  logic              t1_cont;

  assign idx_w = addr_i[IDX_LSB +: IDX_W];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_store
    if (STORE_MASK[i]) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  q <= '0;
        else if (wr_en_i && idx_w == IDX_W'(i))       q <= wdata_i;
      end
      assign store_rd[i] = q;
    end else begin : g_none
      assign store_rd[i] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acr_q <= '0;
    else if (wr_en_i && idx_w == IX_AUX) acr_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) t1_latch_q <= '1;
    else if (wr_en_i && idx_w == IX_LAT_LO) t1_latch_q[DATA_W-1:0]     <= wdata_i;
    else if (wr_en_i && idx_w == IX_LAT_HI) t1_latch_q[CNT_W-1:DATA_W] <= wdata_i;
  end

  periph_down_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_t1 (
    .clk_i, .rst_ni, .tick_i,
    .wr_lo_i    (wr_en_i && idx_w == IX_T1_LO),
    .wr_hi_i    (wr_en_i && idx_w == IX_T1_HI),
    .wdata_i,
    .reload_i   (t1_latch_q),
    .count_o    (t1_count),
    .underflow_o(t1_uf)
  );

  periph_down_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_t2 (
    .clk_i, .rst_ni, .tick_i,
    .wr_lo_i    (wr_en_i && idx_w == IX_T2_LO),
    .wr_hi_i    (wr_en_i && idx_w == IX_T2_HI),
    .wdata_i,
    .reload_i   ('1),
    .count_o    (t2_count),
    .underflow_o(t2_uf)
  );

  assign t1_cont = (acr_q[DATA_W-1 -: 2] == AUX_T1_CONT);

  always_comb begin
    flag_set = '0;
    flag_set[T1_FLAG] = t1_uf & t1_cont;
    flag_clr = '0;
    if (wr_en_i && idx_w == IX_FLAGS) flag_clr = wdata_i[FLAG_W-1:0];
    if (rd_en_i && (idx_w == IX_T1_LO || idx_w == IX_T1_HI)) flag_clr[T1_FLAG] = 1'b1;
  end

  periph_irq_ctrl #(.FLAG_W(FLAG_W)) u_irq (
    .clk_i, .rst_ni,
    .set_i     (flag_set),
    .clr_i     (flag_clr),
    .en_wr_i   (wr_en_i && idx_w == IX_ENABLE),
    .en_wdata_i(wdata_i),
    .flags_o   (ifr),
    .enables_o (ier),
    .irq_o     (irq_o)
  );

  always_comb begin
    unique case (idx_w)
      IX_T1_LO:  rdata_o = t1_count[DATA_W-1:0];
      IX_T1_HI:  rdata_o = t1_count[CNT_W-1:DATA_W];
      IX_LAT_LO: rdata_o = t1_latch_q[DATA_W-1:0];
      IX_LAT_HI: rdata_o = t1_latch_q[CNT_W-1:DATA_W];
      IX_T2_LO:  rdata_o = t2_count[DATA_W-1:0];
      IX_T2_HI:  rdata_o = t2_count[CNT_W-1:DATA_W];
      IX_AUX:    rdata_o = acr_q;
      IX_FLAGS:  rdata_o = {irq_o, ifr};
      IX_ENABLE: rdata_o = {1'b0, ier};
      default:   rdata_o = store_rd[idx_w];
    endcase
  end

  // timer 2 underflow has no flag
  logic unused_t2;
  assign unused_t2 = t2_uf;
endmodule

// File: rtl/periph_timer_chk.sv
module periph_timer_chk
  import periph_timer_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [IDX_W-1:0]  idx_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] acr_i,
  input logic [FLAG_W-1:0] ifr_i,
  input logic [FLAG_W-1:0] ier_i,
  input logic [CNT_W-1:0]  cnt1_i,
  input logic              t1_uf_i,
  input logic              irq_i
);
  a_r4_read_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (idx_i == IX_T1_LO || idx_i == IX_T1_HI) && !t1_uf_i |=> !ifr_i[T1_FLAG]);

  a_r5_latch_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (idx_i == IX_LAT_LO || idx_i == IX_LAT_HI) && !tick_i |=> cnt1_i == $past(cnt1_i));

  a_r6_low_merge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && idx_i == IX_T1_LO |=>
      cnt1_i[CNT_W-1:DATA_W] == $past(cnt1_i[CNT_W-1:DATA_W]) && cnt1_i[DATA_W-1:0] == $past(wdata_i));

  a_r7_flag_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ifr_i[T1_FLAG]) |-> $past(tick_i && acr_i[DATA_W-1 -: 2] == AUX_T1_CONT));

  a_r9_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && idx_i == IX_FLAGS && wdata_i[T1_FLAG] && !t1_uf_i |=> !ifr_i[T1_FLAG]);

  a_r10_enable_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && idx_i == IX_ENABLE && wdata_i[DATA_W-1] |=>
      (ier_i & $past(wdata_i[FLAG_W-1:0])) == $past(wdata_i[FLAG_W-1:0]));

  a_r10_enable_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && idx_i == IX_ENABLE && !wdata_i[DATA_W-1] |=>
      (ier_i & $past(wdata_i[FLAG_W-1:0])) == '0);

  a_r11_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> ier_i != '0);
endmodule

bind periph_timer_regs periph_timer_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .idx_i   (idx_w),
  .wdata_i (wdata_i),
  .acr_i   (acr_q),
  .ifr_i   (ifr),
  .ier_i   (ier),
  .cnt1_i  (t1_count),
  .t1_uf_i (t1_uf),
  .irq_i   (irq_o)
);

// File: tb/periph_timer_regs_test.sv
module periph_timer_regs_test;
  logic clk = 0, rst_ni = 0, tick = 0, wr = 0, rd = 0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  wire  [7:0]  rdata;
  wire         irq;
  bit          done = 0;
  int          checks = 0, fails = 0;

  logic [15:0] m_c1 = 16'hFFFF, m_lat = 16'hFFFF, m_c2 = 16'hFFFF;
  logic [7:0]  m_acr = 0, m_st [16];
  logic [6:0]  m_ier = 0;
  logic        m_f6 = 0;

  always #4 clk = ~clk;

  periph_timer_regs uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .addr_i(addr),
    .wr_en_i(wr), .rd_en_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic m_irq();
    return m_f6 & m_ier[6];
  endfunction

  function automatic logic [7:0] exp_rd(int idx);
    case (idx)
      4: return m_c1[7:0];
      5: return m_c1[15:8];
      6: return m_lat[7:0];
      7: return m_lat[15:8];
      8: return m_c2[7:0];
      9: return m_c2[15:8];
      11: return m_acr;
      13: return {m_irq(), m_f6, 6'b0};
      14: return {1'b0, m_ier};
      default: return m_st[idx];
    endcase
  endfunction

  function automatic string req_of(int idx);
    case (idx)
      4, 5: return "R4";
      6, 7: return "R5";
      8, 9: return "R8";
      13: return "R9";
      14: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_tick();
    if (m_c1 == 0) begin
      m_c1 = m_lat;
      if (m_acr[7:6] == 2'b01) m_f6 = 1;
    end else m_c1 = m_c1 - 1;
    m_c2 = m_c2 - 1;
  endtask

  task automatic peek(int idx, string req);
    @(negedge clk);
    addr = 13'(idx << 9);
    #1 chk(req, rdata, exp_rd(idx));
  endtask

  task automatic do_rd(int idx, string req);
    @(negedge clk);
    addr = 13'(idx << 9) | 13'($urandom_range(0, 511));
    rd = 1;
    #1 chk(req, rdata, exp_rd(idx));
    @(posedge clk); #1 rd = 0;
    if (idx == 4 || idx == 5) m_f6 = 0;
  endtask

  task automatic do_wr(int idx, logic [7:0] d);
    @(negedge clk);
    addr = 13'(idx << 9) | 13'($urandom_range(0, 511));
    wdata = d; wr = 1;
    @(posedge clk); #1 wr = 0;
    case (idx)
      4: m_c1[7:0] = d;
      5: m_c1[15:8] = d;
      6: m_lat[7:0] = d;
      7: m_lat[15:8] = d;
      8: m_c2[7:0] = d;
      9: m_c2[15:8] = d;
      11: m_acr = d;
      13: if (d[6]) m_f6 = 0;
      14: if (d[7]) m_ier = m_ier | d[6:0]; else m_ier = m_ier & ~d[6:0];
      default: m_st[idx] = d;
    endcase
  endtask

  task automatic run_ticks(int n);
    @(negedge clk);
    tick = 1;
    repeat (n) @(posedge clk);
    #1 tick = 0;
    for (int i = 0; i < n; i++) model_tick();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    for (int i = 0; i < 16; i++) m_st[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R3 reset state
    for (int i = 0; i < 16; i++) peek(i, "R3");
    chk("R3 irq", irq, 0);

    // R12 first period from reset
    do_wr(11, 8'h40);
    do_wr(14, 8'hC0);
    run_ticks(65535);
    peek(13, "R12");
    chk("R12 no flag yet", rdata[6], 0);
    run_ticks(1);
    peek(13, "R12");
    chk("R12 flag at 65536", rdata[6], 1);
    chk("R11 irq with flag and enable", irq, 1);

    // R1 peek without strobe leaves flag
    peek(4, "R1");
    peek(5, "R1");
    peek(13, "R1");
    chk("R1 no ack by peek", rdata[6], 1);
    do_rd(5, "R4");
    peek(13, "R4");
    chk("R4 ack by read", rdata[6], 0);
    chk("R11 irq dropped", irq, 0);

    // R1 address bits outside [12:9] ignored
    @(negedge clk); addr = 13'h1800 | 13'h1FF; wdata = 8'h5A; wr = 1;
    @(posedge clk); #1 wr = 0; m_st[12] = 8'h5A;
    peek(12, "R1");

    // R5 latch writes keep the counter
    do_wr(6, 8'h04);
    do_wr(7, 8'h00);
    peek(4, "R5"); peek(5, "R5"); peek(6, "R5"); peek(7, "R5");

    // R6 byte merge, R7 reload period
    do_wr(4, 8'h02);
    peek(5, "R6"); peek(4, "R6");
    do_wr(5, 8'h00);
    peek(4, "R6"); peek(5, "R6");
    run_ticks(2);
    peek(13, "R7");
    chk("R7 no flag before underflow", rdata[6], 0);
    run_ticks(1);
    peek(13, "R7"); peek(4, "R7");
    chk("R7 reloaded to latch", rdata, 8'h04);
    do_wr(13, 8'h00);
    peek(13, "R9");
    chk("R9 zero write keeps flag", rdata[6], 1);
    do_wr(13, 8'h40);
    peek(13, "R9");
    chk("R9 one clears flag", rdata[6], 0);
    run_ticks(5);
    peek(13, "R7");
    chk("R7 period latch+1", rdata[6], 1);
    do_wr(11, 8'h80);
    do_wr(13, 8'hFF);
    run_ticks(20);
    peek(13, "R7");
    chk("R7 no flag outside continuous mode", rdata[6], 0);
    peek(4, "R7");

    // R10 enable set and clear
    do_wr(14, 8'h85);
    peek(14, "R10");
    do_wr(14, 8'h04);
    peek(14, "R10");
    chk("R10 clear bit 2", rdata, 8'h41);

    // R8 timer 2 wrap, no flag
    do_wr(8, 8'h03);
    do_wr(9, 8'h00);
    run_ticks(5);
    peek(8, "R8"); peek(9, "R8");
    chk("R8 wrapped", {rdata}, 8'hFF);
    peek(13, "R8");

    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      int op, idx;
      op  = $urandom_range(0, 2);
      idx = $urandom_range(0, 15);
      if (op == 0) begin
        logic [7:0] d;
        d = 8'($urandom);
        if (idx == 11 && $urandom_range(0, 1) == 1) d[7:6] = 2'b01;
        if ((idx == 6 || idx == 7) && $urandom_range(0, 1) == 1) d = 8'($urandom_range(0, 12));
        do_wr(idx, d);
      end else if (op == 1) begin
        do_rd(idx, req_of(idx));
      end else begin
        run_ticks($urandom_range(1, 40));
      end
      @(negedge clk);
      #1 chk("R11 irq", irq, m_irq());
    end
    for (int i = 0; i < 16; i++) peek(i, req_of(i));

    summary();
  end
endmodule